// File: doc/BRIEF.md
# Row pattern memory self-test controller

This controller checks the data integrity of a synchronous single-port SRAM. After a start pulse it takes one row at a time, in ascending order. For each row it writes a background word and reads it back. It then writes the bitwise complement of that word and reads it back again. Each read is compared with the word that was written, so every stored bit is seen holding both a one and a zero. The test costs four memory operations per row, so the run time grows linearly with the memory depth.

The background word comes from an input and is captured when a start is accepted. A typical choice is an alternating word such as 0xAA, whose complement is 0x55. The controller keeps running to the last row whatever it finds. It keeps the first mismatch it sees: the row, the expected word and the word actually read. When the run ends it raises a one-cycle completion pulse, and a fail flag tells whether any read disagreed.

Top module: `rowtest_ctrl`

## Requirements
- R1: While reset is active and after it is released, busy_o, done_o, fail_o, mem_we_o and mem_re_o are all 0.
- R2: A start_i sampled high while idle captures pattern_i as the background P, and busy_o is 1 in the following cycle. Changes to pattern_i after that do not affect the run.
- R3: The memory sees one operation per cycle. For each row r, from 0 up to DEPTH-1 with DEPTH = 2^ADDR_W, the operations are: write P to r, read r, write ~P to r, read r.
- R4: The memory returns read data one cycle after mem_re_o. That data is compared with P for the first read of a row and with ~P for the second read.
- R5: On the first mismatch of a run, fail_o goes to 1 and err_addr_o, err_exp_o and err_act_o hold the failing row, the expected word and the word read. Later mismatches in the same run leave these values unchanged.
- R6: done_o is high for exactly one cycle, 4*DEPTH+2 cycles after the start edge. busy_o is 1 from the cycle after start through the cycle before done_o, and busy_o is 0 while done_o is 1.
- R7: A start_i pulse while busy_o is 1 has no effect on pattern, sequence or timing, and no second run follows.
- R8: An accepted start clears fail_o. A clean run that follows a failing one ends with fail_o at 0.
- R9: mem_we_o and mem_re_o are never both 1, and neither is 1 while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| pattern_i | input | DATA_W | Background word, captured on an accepted start |
| mem_addr_o | output | ADDR_W | Memory row address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | At least one mismatch in this run |
| err_addr_o | output | ADDR_W | Row of the first mismatch |
| err_exp_o | output | DATA_W | Expected word at the first mismatch |
| err_act_o | output | DATA_W | Word read at the first mismatch |

## Verification
Several properties are checked on every cycle. The write and read strobes never overlap and never fire while idle. done_o lasts one cycle and never coincides with busy_o. A captured error stays frozen until the next accepted start, and an accepted start leaves fail_o clear. Other behaviour can only be shown by the bench scenarios, using a memory model with stuck bits injected per row. These cover the exact operation order per row, completion timing, capture of a fault seen only on the complement read, first-of-two capture, and immunity to a start or pattern change in mid-run.

// File: rtl/rowtest_pkg.sv
package rowtest_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WPAT = 3'd1,
    PH_RPAT = 3'd2,
    PH_WCMP = 3'd3,
    PH_RCMP = 3'd4,
    PH_FIN  = 3'd5
  } phase_e;
endpackage

// File: rtl/rowtest_rst_sync.sv
module rowtest_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/rowtest_seq.sv
module rowtest_seq
  import rowtest_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] pattern_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] rd_exp_o
);
  localparam logic [ADDR_W-1:0] LAST_ROW = {ADDR_W{1'b1}};

  phase_e            state_q, state_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic [DATA_W-1:0] pat_q;
  logic              pat_en;
  logic              done_q, done_d;
  logic              accept;

  assign accept = start_i && (state_q == PH_IDLE);
  assign pat_en = accept;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    done_d  = 1'b0;
    unique case (state_q)
      PH_IDLE: if (accept) begin
        state_d = PH_WPAT;
        row_d   = '0;
      end
      PH_WPAT: state_d = PH_RPAT;
      PH_RPAT: state_d = PH_WCMP;
      PH_WCMP: state_d = PH_RCMP;
      PH_RCMP: begin
        if (row_q == LAST_ROW) state_d = PH_FIN;
        else begin
          state_d = PH_WPAT;
          row_d   = row_q + 1'b1;
        end
      end
      PH_FIN: begin
        state_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (pat_en) pat_q <= pattern_i;
  end

  assign busy_o      = (state_q != PH_IDLE);
  assign done_o      = done_q;
  assign clr_o       = accept;
  assign mem_addr_o  = row_q;
  assign mem_we_o    = (state_q == PH_WPAT) || (state_q == PH_WCMP);
  assign mem_re_o    = (state_q == PH_RPAT) || (state_q == PH_RCMP);
  assign mem_wdata_o = (state_q == PH_WCMP) ? ~pat_q : pat_q;
  assign rd_exp_o    = (state_q == PH_RCMP) ? ~pat_q : pat_q;

  // R9
  no_we_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: rtl/rowtest_cmp.sv
module rowtest_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_act_o
);
  logic              chk_en_q;
  logic [ADDR_W-1:0] chk_addr_q;
  logic [DATA_W-1:0] chk_exp_q;
  logic              mismatch;
  logic              cap_en;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] err_addr_q;
  logic [DATA_W-1:0] err_exp_q, err_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en_q   <= 1'b0;
      chk_addr_q <= '0;
      chk_exp_q  <= '0;
    end else begin
      chk_en_q <= rd_en_i;
      if (rd_en_i) begin
        chk_addr_q <= rd_addr_i;
        chk_exp_q  <= rd_exp_i;
      end
    end
  end

  assign mismatch = chk_en_q && (rdata_i != chk_exp_q);
  assign cap_en   = mismatch && !fail_q && !clr_i;

  always_comb begin
    fail_d = fail_q;
    if (clr_i)       fail_d = 1'b0;
    else if (cap_en) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_addr_q <= '0;
      err_exp_q  <= '0;
      err_act_q  <= '0;
    end else if (clr_i) begin
      err_addr_q <= '0;
      err_exp_q  <= '0;
      err_act_q  <= '0;
    end else if (cap_en) begin
      err_addr_q <= chk_addr_q;
      err_exp_q  <= chk_exp_q;
      err_act_q  <= rdata_i;
    end
  end

  assign fail_o     = fail_q;
  assign err_addr_o = err_addr_q;
  assign err_exp_o  = err_exp_q;
  assign err_act_o  = err_act_q;

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> ($stable(err_addr_o) && $stable(err_exp_o) && $stable(err_act_o)));

  // R8
  clr_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !fail_o);
endmodule

// File: rtl/rowtest_ctrl.sv
module rowtest_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] pattern_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_act_o
);
  logic              rst_n_s;
  logic              clr;
  logic [DATA_W-1:0] rd_exp;

  rowtest_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  rowtest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .pattern_i   (pattern_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .clr_o       (clr),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .rd_exp_o    (rd_exp)
  );

  rowtest_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (clr),
    .rd_en_i    (mem_re_o),
    .rd_addr_i  (mem_addr_o),
    .rd_exp_i   (rd_exp),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .err_addr_o (err_addr_o),
    .err_exp_o  (err_exp_o),
    .err_act_o  (err_act_o)
  );
endmodule

// File: tb/tb_rowtest_ctrl.sv
module tb_rowtest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NOPS   = 4 * DEPTH;
  localparam int DONE_AT = 4 * DEPTH + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [DATA_W-1:0] pattern_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o;
  logic              mem_we_o, mem_re_o;
  logic [DATA_W-1:0] mem_rdata_i;
  logic              busy_o, done_o, fail_o;
  logic [ADDR_W-1:0] err_addr_o;
  logic [DATA_W-1:0] err_exp_o, err_act_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  rowtest_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pattern_i(pattern_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .err_addr_o(err_addr_o),
    .err_exp_o(err_exp_o), .err_act_o(err_act_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model with per-row stuck bits
  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] smask [DEPTH];
  logic [DATA_W-1:0] sval  [DEPTH];

  // operation log: kind 1 = write, 0 = read
  logic              op_kind [NOPS];
  logic [ADDR_W-1:0] op_addr [NOPS];
  logic [DATA_W-1:0] op_data [NOPS];
  int                op_cnt;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_we_o)
      mem[mem_addr_o] <= (mem_wdata_o & ~smask[mem_addr_o]) | (sval[mem_addr_o] & smask[mem_addr_o]);
    if (mem_re_o)
      mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o || mem_re_o) begin
      if (op_cnt < NOPS) begin
        op_kind[op_cnt] <= mem_we_o;
        op_addr[op_cnt] <= mem_addr_o;
        op_data[op_cnt] <= mem_wdata_o;
      end
      op_cnt <= op_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < DEPTH; i++) begin
      smask[i] = '0;
      sval[i]  = '0;
    end
  endtask

  // run one test; returns cycle count at which done appeared and busy errors
  task automatic run(input logic [DATA_W-1:0] pat, input int mid_start_at,
                     input logic [DATA_W-1:0] alt_pat, output int done_cyc, output int busy_err);
    int cyc;
    @(negedge clk);
    op_cnt = 0;
    start_i = 1'b1;
    pattern_i = pat;
    @(negedge clk);
    start_i = 1'b0;
    pattern_i = alt_pat;
    cyc = 1;
    busy_err = 0;
    done_cyc = -1;
    while (cyc < 4 * DONE_AT) begin
      if (done_o) begin
        done_cyc = cyc;
        if (busy_o) busy_err++;
        break;
      end
      if (!busy_o) busy_err++;
      start_i = (cyc == mid_start_at);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
  endtask

  task automatic check_ops(input logic [DATA_W-1:0] pat, input string req);
    int nbad = 0;
    int first = -1;
    for (int i = 0; i < NOPS; i++) begin
      logic wk;
      logic [DATA_W-1:0] wd;
      wk = ((i % 4) == 0) || ((i % 4) == 2);
      wd = ((i % 4) == 0) ? pat : ~pat;
      if (op_kind[i] != wk || op_addr[i] != ADDR_W'(i / 4) || (wk && op_data[i] != wd)) begin
        nbad++;
        if (first < 0) first = i;
      end
    end
    chk(nbad == 0 && op_cnt == NOPS, req, first, -1);
  endtask

  task automatic check_mem(input logic [DATA_W-1:0] expv, input string req);
    int nbad = 0;
    int act = 0;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] != expv) begin
        nbad++;
        act = int'(mem[i]);
      end
    chk(nbad == 0, req, nbad == 0 ? int'(expv) : act, int'(expv));
  endtask

  task automatic t_reset();
    // R1: idle outputs low after reset
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    chk(!fail_o, "R1 fail", fail_o, 0);
    chk(!mem_we_o && !mem_re_o, "R1 strobes", {mem_we_o, mem_re_o}, 0);
  endtask

  task automatic t_clean(input logic [DATA_W-1:0] pat);
    int dc, be;
    clear_faults();
    run(pat, -1, pat, dc, be);
    // R6: completion timing and busy window
    chk(dc == DONE_AT, "R6 done cycle", dc, DONE_AT);
    chk(be == 0, "R6 busy window", be, 0);
    // R3: operation order and data
    check_ops(pat, "R3 op order");
    // R4: no mismatch on a clean memory
    chk(!fail_o, "R4 clean compare", fail_o, 0);
    check_mem(~pat, "R3 complement left");
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", done_o, 0);
  endtask

  task automatic t_fault_p2();
    int dc, be;
    clear_faults();
    smask[5] = 8'h01; sval[5] = 8'h01;
    run(8'hAA, -1, 8'hAA, dc, be);
    // R5 / R4: phase-two mismatch captured at row 5
    chk(fail_o, "R5 fail set", fail_o, 1);
    chk(err_addr_o == 5, "R5 addr", err_addr_o, 5);
    chk(err_exp_o == 8'hAA, "R5 exp", err_exp_o, 8'hAA);
    chk(err_act_o == 8'hAB, "R5 act", err_act_o, 8'hAB);
    chk(dc == DONE_AT, "R6 done with fault", dc, DONE_AT);
  endtask

  task automatic t_fault_p4();
    int dc, be;
    clear_faults();
    smask[7] = 8'h01; sval[7] = 8'h00;
    run(8'hAA, -1, 8'hAA, dc, be);
    // R4: only the complement read sees the fault; R8 start cleared prior fail
    chk(fail_o, "R4 complement fail", fail_o, 1);
    chk(err_addr_o == 7, "R4 addr", err_addr_o, 7);
    chk(err_exp_o == 8'h55, "R4 exp", err_exp_o, 8'h55);
    chk(err_act_o == 8'h54, "R4 act", err_act_o, 8'h54);
  endtask

  task automatic t_two_faults();
    int dc, be;
    clear_faults();
    smask[3] = 8'h80; sval[3] = 8'h00;
    smask[9] = 8'h01; sval[9] = 8'h01;
    run(8'hAA, -1, 8'hAA, dc, be);
    // R5: first mismatch kept
    chk(err_addr_o == 3, "R5 first addr", err_addr_o, 3);
    chk(err_act_o == 8'h2A, "R5 first act", err_act_o, 8'h2A);
    chk(err_exp_o == 8'hAA, "R5 first exp", err_exp_o, 8'hAA);
  endtask

  task automatic t_clear_after_fail();
    int dc, be;
    clear_faults();
    run(8'h3C, -1, 8'h3C, dc, be);
    // R8: clean run after failing run
    chk(!fail_o, "R8 fail cleared", fail_o, 0);
  endtask

  task automatic t_busy_start();
    int dc, be;
    clear_faults();
    run(8'hAA, 10, 8'h0F, dc, be);
    // R7: start in mid-run ignored; R2 pattern change ignored
    chk(dc == DONE_AT, "R7 timing", dc, DONE_AT);
    check_ops(8'hAA, "R7 ops unchanged");
    check_mem(8'h55, "R2 latched pattern");
    repeat (5) @(negedge clk);
    chk(!busy_o, "R7 no second run", busy_o, 0);
  endtask

  task automatic t_latch();
    int dc, be;
    clear_faults();
    run(8'h3C, -1, 8'hFF, dc, be);
    // R2: pattern captured at start
    check_mem(8'hC3, "R2 pattern latch");
    check_ops(8'h3C, "R2 ops use latched");
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    pattern_i = '0;
    op_cnt = 0;
    clear_faults();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_clean(8'hAA);
    t_clean(8'h3C);
    t_fault_p2();
    t_fault_p4();
    t_two_faults();
    t_clear_after_fail();
    t_busy_start();
    t_latch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule